// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for up to sixteen pins (twelve by default, eight as a common smaller option). Software sets each pin's direction and output level through word-addressed registers on a simple 32-bit read/write bus. It can also read back the pin levels after a two-flop synchronizer.

Every pin has its own interrupt detector, which can be set to fire on a falling edge, a rising edge, either edge, a low level or a high level. A detected condition on an enabled pin sets a sticky status bit, which software clears by writing ones. A per-pin mask is changed through separate write-one-to-set and write-one-to-clear addresses. All unmasked status bits are combined into one interrupt line. A soft-reset register holds the whole controller at its default state while its bit is 1.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset the mask reads all ones over the implemented pins (0xFFF for twelve pins). Enable, direction, output, use-select, status and every mode slot read 0, and `irq` is low.
- R2: Direction register (byte offset 0x20) bit i = 1 drives `pad_oe[i]` high, so the pin is an output with the level of output register (0x18) bit i on `pad_out[i]`. Only the low pin-count bits of either register are stored.
- R3: The input register (0x1C) returns the pin levels, bit i for pin i, taken after a two-flop synchronizer. A pad change can be read from the third clock edge onward.
- R4: Pin i has a 3-bit mode code at bits 4*(i mod 8)+2..4*(i mod 8) of mode register 0 (0x24) for pins 0-7, and of mode register 1 (0x28) for pins 8 and above. The fourth bit of each slot and the slots of absent pins read 0.
- R5: Writing 1 to bit i at 0x10 masks pin i, and writing 1 to bit i at 0x14 unmasks it. Zero bits leave the mask unchanged, and both offsets read back the mask.
- R6: A status bit latches only when the pin's enable bit (0x00) is 1 and the pin's mode condition is seen. Mode 0 is a falling edge, mode 1 a rising edge and mode 4 either edge. Codes 5-7 detect nothing. A pad edge sets the status on the third clock edge after the change.
- R7: Mode 2 (level low) and mode 3 (level high) set the status bit again on every cycle while the level persists and the pin is enabled.
- R8: Writing 1 to bit i of the clear register (0x0C) clears status bit i. A detection in the same cycle wins over the clear.
- R9: `irq` is the OR over pins of status AND NOT mask. The pending register (0x08) reads status AND NOT mask, and the status register (0x04) reads the raw status.
- R10: Writing 1 to bit 0 of the soft-reset register (0x3C) holds every other register at its R1 value and ignores writes to them. Writing 0 releases the block.
- R11: Read data appears on `bus_rdata` one cycle after a read request. Offsets with no register read 0. The use-select register (0x38) stores the low pin-count bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the word (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pad_in | input | NUM_PINS | Pin levels from the pads |
| pad_out | output | NUM_PINS | Output levels to the pads |
| pad_oe | output | NUM_PINS | Output enables to the pads |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the clock edge that samples it. The bench therefore checks `pad_out`, `pad_oe` and `irq` at the falling edge after a write returns, and read data one falling edge after the read request. A pad change takes three rising edges to set a status bit: two for the synchronizer and one for the status flop. Positive detection checks wait exactly three falling edges after the pad change. Checks that expect no interrupt wait four, so a late set would still be caught.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [2:0] {
        MODE_FALL = 3'd0,
        MODE_RISE = 3'd1,
        MODE_LOW  = 3'd2,
        MODE_HIGH = 3'd3,
        MODE_BOTH = 3'd4
    } gpio_mode_e;

    // word index = byte offset / 4
    localparam logic [3:0] W_ENABLE  = 4'h0;
    localparam logic [3:0] W_STATUS  = 4'h1;
    localparam logic [3:0] W_PENDING = 4'h2;
    localparam logic [3:0] W_CLEAR   = 4'h3;
    localparam logic [3:0] W_MSET    = 4'h4;
    localparam logic [3:0] W_MCLR    = 4'h5;
    localparam logic [3:0] W_DOUT    = 4'h6;
    localparam logic [3:0] W_DIN     = 4'h7;
    localparam logic [3:0] W_DIR     = 4'h8;
    localparam logic [3:0] W_MODE0   = 4'h9;
    localparam logic [3:0] W_MODE1   = 4'hA;
    localparam logic [3:0] W_USESEL  = 4'hE;
    localparam logic [3:0] W_SRST    = 4'hF;
endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);
    logic [N-1:0] meta_d, meta_q, lvl_d, lvl_q, prev_d, prev_q;
    logic [1:0]   warm_d, warm_q;

    always_comb begin
        meta_d = pad_in;
        lvl_d  = meta_q;
        prev_d = lvl_q;
        warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
            warm_q <= '0;
        end else begin
            meta_q <= meta_d;
            lvl_q  <= lvl_d;
            prev_q <= prev_d;
            warm_q <= warm_d;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (lvl_q == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int N = 12
) (
    input  logic [N-1:0]   lvl_i,
    input  logic [N-1:0]   prev_i,
    input  logic [3*N-1:0] mode_i,
    output logic [N-1:0]   hit_o
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic hit_b;
        always_comb begin
            case (gpio_mode_e'(mode_i[3*i +: 3]))
                MODE_FALL: hit_b = ~lvl_i[i] &  prev_i[i];
                MODE_RISE: hit_b =  lvl_i[i] & ~prev_i[i];
                MODE_LOW:  hit_b = ~lvl_i[i];
                MODE_HIGH: hit_b =  lvl_i[i];
                MODE_BOTH: hit_b =  lvl_i[i] ^  prev_i[i];
                default:   hit_b = 1'b0;
            endcase
        end
        assign hit_o[i] = hit_b;
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_wr,
    input  logic [5:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int N  = NUM_PINS;
    localparam int MW = 3 * N;

    typedef struct packed {
        logic [N-1:0]  en;
        logic [N-1:0]  stat;
        logic [N-1:0]  mask;
        logic [N-1:0]  dout;
        logic [N-1:0]  dir;
        logic [N-1:0]  usel;
        logic [MW-1:0] mode;
        logic          srst;
        logic [31:0]   rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{en: '0, stat: '0, mask: '1, dout: '0,
                                   dir: '0, usel: '0, mode: '0, srst: 1'b0,
                                   rdata: '0};

    regs_t r_d, r_q;
    logic [N-1:0] lvl, prev, hit, pend;
    logic [3:0]   widx;
    logic         wr_en, rd_en;
    logic [31:0]  mode0_rd, mode1_rd, rd_val;
    logic         unused_bits;

    gpio_sync_bank #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl_o(lvl), .prev_o(prev)
    );

    gpio_detect #(.N(N)) u_detect (
        .lvl_i(lvl), .prev_i(prev), .mode_i(r_q.mode), .hit_o(hit)
    );

    assign widx  = bus_addr[5:2];
    assign wr_en = bus_req & bus_wr;
    assign rd_en = bus_req & ~bus_wr;
    assign pend  = r_q.stat & ~r_q.mask;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    // mode readback: one 4-bit slot per pin, top bit of each slot is 0
    always_comb begin
        mode0_rd = '0;
        mode1_rd = '0;
        for (int i = 0; i < N; i++) begin
            if (i < 8) mode0_rd[(i % 8) * 4 +: 3] = r_q.mode[i * 3 +: 3];
            else       mode1_rd[(i % 8) * 4 +: 3] = r_q.mode[i * 3 +: 3];
        end
    end

    always_comb begin
        rd_val = '0;
        case (widx)
            W_ENABLE:        rd_val[N-1:0] = r_q.en;
            W_STATUS:        rd_val[N-1:0] = r_q.stat;
            W_PENDING:       rd_val[N-1:0] = pend;
            W_MSET, W_MCLR:  rd_val[N-1:0] = r_q.mask;
            W_DOUT:          rd_val[N-1:0] = r_q.dout;
            W_DIN:           rd_val[N-1:0] = lvl;
            W_DIR:           rd_val[N-1:0] = r_q.dir;
            W_MODE0:         rd_val        = mode0_rd;
            W_MODE1:         rd_val        = mode1_rd;
            W_USESEL:        rd_val[N-1:0] = r_q.usel;
            W_SRST:          rd_val[0]     = r_q.srst;
            default:         rd_val        = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        // detection wins over a simultaneous clear
        r_d.stat = r_q.stat & ~((wr_en && widx == W_CLEAR) ? bus_wdata[N-1:0] : '0);
        r_d.stat = r_d.stat | (hit & r_q.en);
        if (wr_en) begin
            case (widx)
                W_ENABLE: r_d.en   = bus_wdata[N-1:0];
                W_MSET:   r_d.mask = r_q.mask | bus_wdata[N-1:0];
                W_MCLR:   r_d.mask = r_q.mask & ~bus_wdata[N-1:0];
                W_DOUT:   r_d.dout = bus_wdata[N-1:0];
                W_DIR:    r_d.dir  = bus_wdata[N-1:0];
                W_USESEL: r_d.usel = bus_wdata[N-1:0];
                W_SRST:   r_d.srst = bus_wdata[0];
                W_MODE0, W_MODE1: begin
                    for (int i = 0; i < N; i++) begin
                        if ((i < 8) == (widx == W_MODE0))
                            r_d.mode[i * 3 +: 3] = bus_wdata[(i % 8) * 4 +: 3];
                    end
                end
                default: ;
            endcase
        end
        if (r_q.srst) begin
            r_d      = REGS_RST;
            r_d.srst = (wr_en && widx == W_SRST) ? bus_wdata[0] : 1'b1;
        end
        r_d.rdata = rd_en ? rd_val : r_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign pad_out   = r_q.dout;
    assign pad_oe    = r_q.dir;
    assign irq       = |pend;

    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_MSET && !r_q.srst) |=>
        ((r_q.mask & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_MCLR && !r_q.srst) |=>
        ((r_q.mask & $past(bus_wdata[N-1:0])) == '0));

    // R6
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.stat & ~$past(r_q.stat) & ~$past(r_q.en)) == '0));

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_CLEAR && !r_q.srst) |=>
        ((r_q.stat & $past(bus_wdata[N-1:0]) & ~$past(r_q.en)) == '0));

    // R10
    srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.srst && $past(r_q.srst)) |->
        (r_q.mask == '1 && r_q.en == '0 && r_q.dir == '0 && !irq));
endmodule

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
    localparam int N = 12;
    localparam logic [31:0] ALL = 32'h0000_0FFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic          irq;
    int            n_cmp = 0, n_bad = 0;
    logic [31:0]   rv;

    always #5 clk = ~clk;

    gpio_ctrl #(.NUM_PINS(N)) u_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic settle();  repeat (3) @(negedge clk); endtask
    task automatic quiet();   repeat (4) @(negedge clk); endtask

    task automatic t_reset();
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 pad_oe after reset", {20'd0, pad_oe}, 32'd0);
        rd(6'h10, rv); chk("R1 mask all set", rv, ALL);
        rd(6'h00, rv); chk("R1 enable clear", rv, 32'd0);
        rd(6'h20, rv); chk("R1 direction input", rv, 32'd0);
        rd(6'h24, rv); chk("R1 mode0 zero", rv, 32'd0);
        rd(6'h04, rv); chk("R1 status zero", rv, 32'd0);
    endtask

    task automatic t_dir_out();
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, rv); chk("R2 direction width", rv, ALL);
        wr(6'h18, 32'hFFFF_FA5A);
        chk("R2 pad_out", {20'd0, pad_out}, 32'hA5A);
        chk("R2 pad_oe all", {20'd0, pad_oe}, ALL);
        wr(6'h20, 32'h0000_000F);
        chk("R2 pad_oe low nibble", {20'd0, pad_oe}, 32'h00F);
        wr(6'h20, 32'd0);
    endtask

    task automatic t_input();
        pad_in = 12'h3C5;
        settle();
        rd(6'h1C, rv); chk("R3 input readback", rv, 32'h3C5);
        pad_in = '0;
        settle();
        rd(6'h1C, rv); chk("R3 input readback zero", rv, 32'h0);
    endtask

    task automatic t_mode_fields();
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h24, rv); chk("R4 mode0 slot bits", rv, 32'h7777_7777);
        wr(6'h28, 32'hFFFF_FFFF);
        rd(6'h28, rv); chk("R4 mode1 slot bits", rv, 32'h0000_7777);
        wr(6'h24, 32'd0);
        wr(6'h28, 32'd0);
    endtask

    task automatic t_mask();
        wr(6'h14, 32'h005);
        rd(6'h10, rv); chk("R5 mask clear bits", rv, 32'hFFA);
        wr(6'h10, 32'h000);
        rd(6'h14, rv); chk("R5 mask set zero no effect", rv, 32'hFFA);
        wr(6'h14, 32'h000);
        rd(6'h10, rv); chk("R5 mask clear zero no effect", rv, 32'hFFA);
        wr(6'h10, 32'h001);
        rd(6'h10, rv); chk("R5 mask set bit", rv, 32'hFFB);
        wr(6'h10, 32'hFFF);
    endtask

    task automatic t_rising();
        wr(6'h24, 32'h0000_0100);
        wr(6'h00, 32'h004);
        wr(6'h14, 32'h004);
        pad_in[2] = 1'b1;
        settle();
        chk("R6 rising edge irq", {31'd0, irq}, 32'd1);
        wr(6'h0C, 32'h004);
        chk("R8 clear drops irq", {31'd0, irq}, 32'd0);
        pad_in[2] = 1'b0;
        quiet();
        chk("R6 falling ignored in rise mode", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_disabled();
        wr(6'h00, 32'h000);
        pad_in[2] = 1'b1;
        quiet();
        rd(6'h04, rv); chk("R6 disabled pin no latch", rv, 32'd0);
        pad_in[2] = 1'b0;
        quiet();
        wr(6'h00, 32'h004);
    endtask

    task automatic t_fall_both();
        wr(6'h24, 32'h0000_0000);
        pad_in[2] = 1'b1;
        quiet();
        chk("R6 rise ignored in fall mode", {31'd0, irq}, 32'd0);
        pad_in[2] = 1'b0;
        settle();
        chk("R6 falling edge irq", {31'd0, irq}, 32'd1);
        wr(6'h0C, 32'h004);
        wr(6'h24, 32'h0000_0400);
        pad_in[2] = 1'b1;
        settle();
        chk("R6 both mode rise", {31'd0, irq}, 32'd1);
        wr(6'h0C, 32'h004);
        pad_in[2] = 1'b0;
        settle();
        chk("R6 both mode fall", {31'd0, irq}, 32'd1);
        wr(6'h0C, 32'h004);
        chk("R8 clear after both", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_level();
        wr(6'h24, 32'h0000_0300);
        pad_in[2] = 1'b1;
        settle();
        chk("R7 level high irq", {31'd0, irq}, 32'd1);
        wr(6'h0C, 32'h004);
        chk("R7 level high reasserts over clear", {31'd0, irq}, 32'd1);
        rd(6'h04, rv); chk("R7 status held by level", rv, 32'h004);
        pad_in[2] = 1'b0;
        settle();
        wr(6'h0C, 32'h004);
        chk("R8 clear after level drops", {31'd0, irq}, 32'd0);
        wr(6'h24, 32'h0000_0200);
        repeat (2) @(negedge clk);
        chk("R7 level low irq", {31'd0, irq}, 32'd1);
        wr(6'h24, 32'h0000_0100);
        wr(6'h0C, 32'h004);
        chk("R8 clear after mode change", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_mask_pending();
        wr(6'h10, 32'hFFF);
        wr(6'h24, 32'h0010_0000);
        wr(6'h00, 32'h020);
        pad_in[5] = 1'b1;
        settle();
        chk("R9 masked pin no irq", {31'd0, irq}, 32'd0);
        rd(6'h04, rv); chk("R9 raw status", rv, 32'h020);
        rd(6'h08, rv); chk("R9 pending masked", rv, 32'h000);
        wr(6'h14, 32'h020);
        chk("R9 unmask raises irq", {31'd0, irq}, 32'd1);
        rd(6'h08, rv); chk("R9 pending unmasked", rv, 32'h020);
        wr(6'h0C, 32'h020);
        pad_in[5] = 1'b0;
        quiet();
        wr(6'h10, 32'h020);
    endtask

    task automatic t_mode1();
        wr(6'h28, 32'h0000_0010);
        rd(6'h28, rv); chk("R4 mode1 pin9 slot", rv, 32'h10);
        wr(6'h00, 32'h200);
        wr(6'h14, 32'h200);
        pad_in[9] = 1'b1;
        settle();
        chk("R4 pin9 rising via mode1", {31'd0, irq}, 32'd1);
        wr(6'h0C, 32'h200);
        pad_in[9] = 1'b0;
        quiet();
        chk("R4 pin9 falling ignored", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_bus_misc();
        wr(6'h38, 32'hFFFF_FFFF);
        rd(6'h38, rv); chk("R11 use-select width", rv, ALL);
        rd(6'h30, rv); chk("R11 unmapped reads zero", rv, 32'd0);
        rd(6'h2C, rv); chk("R11 unmapped reads zero 2", rv, 32'd0);
    endtask

    task automatic t_srst();
        wr(6'h20, 32'h0FF);
        wr(6'h00, 32'hFFF);
        wr(6'h14, 32'hFFF);
        wr(6'h3C, 32'h1);
        wr(6'h20, 32'h00F);
        rd(6'h10, rv); chk("R10 mask during hold", rv, ALL);
        rd(6'h20, rv); chk("R10 write ignored during hold", rv, 32'd0);
        wr(6'h3C, 32'h0);
        rd(6'h20, rv); chk("R10 direction default", rv, 32'd0);
        rd(6'h00, rv); chk("R10 enable default", rv, 32'd0);
        rd(6'h10, rv); chk("R10 mask default", rv, ALL);
        rd(6'h38, rv); chk("R10 use-select default", rv, 32'd0);
        rd(6'h28, rv); chk("R10 mode1 default", rv, 32'd0);
        chk("R10 pad_oe default", {20'd0, pad_oe}, 32'd0);
        wr(6'h20, 32'h003);
        chk("R10 released block accepts writes", {20'd0, pad_oe}, 32'h003);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_dir_out();
        t_input();
        t_mode_fields();
        t_mask();
        t_rising();
        t_disabled();
        t_fall_both();
        t_level();
        t_mask_pending();
        t_mode1();
        t_bus_misc();
        t_srst();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule